// File: doc/BRIEF.md
# Programmable Logic Configuration Sequencer

This block is the device-side control machine that takes a programmable logic device from power-up to user mode. It waits for a power-good indication and then runs a power-on-reset delay whose length comes from the mode-select code. It holds the device in reset while the active-low configuration request is low. When the request goes high it releases the status line. It then takes one configuration word for each configuration clock enable pulse, counting words against a supplied total bitstream length. After the last word it releases the done line. Initialization starts only once the sensed done line is seen to rise. When initialization ends, the user I/O drivers are enabled and the user-mode flag is raised.

The status and done lines are modelled as open-drain nets. The block only decides whether to pull each line low (`*_drive_low_o`). The resolved level of each wire comes back on `status_line_i` and `done_line_i`, so an external agent can hold either line low. The bitstream is not decoded. It is only counted, and each captured word is presented for one cycle.

Top module: `cfg_sequencer`

## Requirements
- R1: While power-good is low, and while `rst_ni` is low, the block pulls both the status line and the done line low, keeps `io_tristate_o` at 1 and keeps `user_mode_o` at 0. Dropping power-good in any state returns the block to this condition on the next cycle.
- R2: The power-on-reset delay lasts `POR_FAST` cycles when bit 0 of the mode code is 0 and `POR_SLOW` cycles when it is 1. The mode code is sampled once, in the cycle power-good is first seen high, and later changes to it have no effect.
- R3: While `cfg_req_ni` is low the status line stays pulled low. The status line is released two cycles after the power-on-reset delay ends, or one cycle after `cfg_req_ni` is seen high in reset.
- R4: A word is captured only in a cycle where the block is configuring, the sensed status line reads 1 and `cfg_clk_en_i` is 1. For each captured word, `cfg_word_vld_o` is 1 for exactly the following cycle.
- R5: When bit 1 of the mode code is 0 (serial scheme), only `cfg_data_i[0]` is captured and the upper bits of `cfg_word_o` read 0. When bit 1 is 1 (parallel scheme), all `DATA_W` bits are captured.
- R6: The done line is released in the cycle after the capture of word number `total_words_i`, and not before.
- R7: Initialization starts only on a low-to-high transition of the sensed done line. While the done line is held low externally, `io_tristate_o` stays 1 and `user_mode_o` stays 0.
- R8: `INIT_CYCLES` cycles after the done-line rise is registered, `user_mode_o` goes to 1 and `io_tristate_o` goes to 0. Both the status and done lines stay released in user mode.
- R9: With power good, `cfg_req_ni` low in any state returns the block to reset on the next cycle. Reset pulls the status and done lines low, tri-states the user I/O, suppresses any capture in that same cycle and clears the word count, so the next bitstream needs `total_words_i` fresh words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supplies are valid |
| mode_sel_i | input | 2 | Scheme code: bit 0 picks the long delay, bit 1 picks the parallel bus |
| cfg_req_ni | input | 1 | Active-low configuration request |
| cfg_clk_en_i | input | 1 | Configuration clock pulse, one word per high cycle |
| cfg_data_i | input | DATA_W | Configuration data bus |
| total_words_i | input | LEN_W | Bitstream length in words |
| status_line_i | input | 1 | Sensed level of the status wire |
| done_line_i | input | 1 | Sensed level of the done wire |
| status_drive_low_o | output | 1 | 1 pulls the status wire low |
| done_drive_low_o | output | 1 | 1 pulls the done wire low |
| io_tristate_o | output | 1 | 1 keeps user I/O drivers off |
| user_mode_o | output | 1 | Device is in user mode |
| cfg_word_o | output | DATA_W | Last captured word |
| cfg_word_vld_o | output | 1 | `cfg_word_o` holds a new word |

## Verification
Two events can fall in the same cycle: the final word capture and a falling configuration request. The bench drives the last word's clock pulse together with `cfg_req_ni` low at one negative edge. It then expects reset to win: no valid word, the done line still pulled low and the status line pulled low again. It then shows that a full count of fresh words is needed before the done line is released.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_POR,
    ST_RESET,
    ST_CONFIG,
    ST_WAIT_DONE,
    ST_INIT,
    ST_USER
  } seq_state_e;
endpackage

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_seq_word_cnt.sv
module cfg_seq_word_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] total_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  // a zero length behaves as one word
  assign last_o = ({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, total_i};
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int POR_FAST    = 16,
  parameter int POR_SLOW    = 64,
  parameter int INIT_CYCLES = 8,
  parameter int TMR_W       = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic              cfg_req_ni,
  input  logic              cfg_clk_en_i,
  input  logic              status_line_i,
  input  logic              done_line_i,
  input  logic              tmr_zero_i,
  input  logic              cnt_last_i,
  output seq_state_e        state_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              tmr_load_o,
  output logic [TMR_W-1:0]  tmr_load_val_o,
  output logic              tmr_dec_o,
  output logic              cnt_clr_o,
  output logic              capture_o
);
  localparam logic [TMR_W-1:0] FAST_LD = TMR_W'(POR_FAST - 1);
  localparam logic [TMR_W-1:0] SLOW_LD = TMR_W'(POR_SLOW - 1);
  localparam logic [TMR_W-1:0] INIT_LD = TMR_W'(INIT_CYCLES - 1);

  seq_state_e        state_q, state_d;
  logic [MODE_W-1:0] mode_q;
  logic              done_prev_q;
  logic              done_rise;

  assign done_rise = done_line_i && !done_prev_q;

  always_comb begin
    state_d        = state_q;
    tmr_load_o     = 1'b0;
    tmr_load_val_o = '0;
    tmr_dec_o      = 1'b0;
    cnt_clr_o      = 1'b0;
    capture_o      = 1'b0;
    if (!pwr_good_i) begin
      state_d   = ST_OFF;
      cnt_clr_o = 1'b1;
    end else if (!cfg_req_ni && state_q != ST_OFF && state_q != ST_POR) begin
      state_d   = ST_RESET;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d        = ST_POR;
          tmr_load_o     = 1'b1;
          tmr_load_val_o = mode_sel_i[0] ? SLOW_LD : FAST_LD;
          cnt_clr_o      = 1'b1;
        end
        ST_POR: begin
          cnt_clr_o = 1'b1;
          if (tmr_zero_i) state_d = ST_RESET;
          else            tmr_dec_o = 1'b1;
        end
        ST_RESET: begin
          cnt_clr_o = 1'b1;
          state_d   = ST_CONFIG;
        end
        ST_CONFIG: begin
          if (status_line_i && cfg_clk_en_i) begin
            capture_o = 1'b1;
            if (cnt_last_i) state_d = ST_WAIT_DONE;
          end
        end
        ST_WAIT_DONE: begin
          if (done_rise) begin
            state_d        = ST_INIT;
            tmr_load_o     = 1'b1;
            tmr_load_val_o = INIT_LD;
          end
        end
        ST_INIT: begin
          if (tmr_zero_i) state_d = ST_USER;
          else            tmr_dec_o = 1'b1;
        end
        ST_USER: state_d = ST_USER;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OFF;
      mode_q      <= '0;
      done_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      done_prev_q <= done_line_i;
      if (state_q == ST_OFF && pwr_good_i) mode_q <= mode_sel_i;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;

  // R7
  init_needs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && $past(state_q) == ST_WAIT_DONE) |-> $past(done_line_i && !done_prev_q));

  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_DONE && $past(state_q) == ST_CONFIG) |-> $past(cnt_last_i && capture_o));
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 16,
  parameter int POR_FAST    = 16,
  parameter int POR_SLOW    = 64,
  parameter int INIT_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic              cfg_req_ni,
  input  logic              cfg_clk_en_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic [LEN_W-1:0]  total_words_i,
  input  logic              status_line_i,
  input  logic              done_line_i,
  output logic              status_drive_low_o,
  output logic              done_drive_low_o,
  output logic              io_tristate_o,
  output logic              user_mode_o,
  output logic [DATA_W-1:0] cfg_word_o,
  output logic              cfg_word_vld_o
);
  localparam int POR_MAX = (POR_SLOW > POR_FAST) ? POR_SLOW : POR_FAST;
  localparam int DLY_MAX = (POR_MAX > INIT_CYCLES) ? POR_MAX : INIT_CYCLES;
  localparam int TMR_W   = $clog2(DLY_MAX + 1);

  seq_state_e        state;
  logic [MODE_W-1:0] mode_q;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]  tmr_load_val;
  logic              cnt_clr, cnt_last, capture;
  logic [DATA_W-1:0] serial_word, word_d;
  logic [DATA_W-1:0] word_q;
  logic              vld_q;

  cfg_seq_fsm #(
    .POR_FAST(POR_FAST), .POR_SLOW(POR_SLOW),
    .INIT_CYCLES(INIT_CYCLES), .TMR_W(TMR_W)
  ) u_fsm (
    .clk_i, .rst_ni, .pwr_good_i, .mode_sel_i, .cfg_req_ni, .cfg_clk_en_i,
    .status_line_i, .done_line_i,
    .tmr_zero_i(tmr_zero), .cnt_last_i(cnt_last),
    .state_o(state), .mode_o(mode_q),
    .tmr_load_o(tmr_load), .tmr_load_val_o(tmr_load_val), .tmr_dec_o(tmr_dec),
    .cnt_clr_o(cnt_clr), .capture_o(capture)
  );

  // shared by the power-on delay and initialization
  cfg_seq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_load_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  cfg_seq_word_cnt #(.LEN_W(LEN_W)) u_word_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(capture),
    .total_i(total_words_i), .last_o(cnt_last)
  );

  generate
    if (DATA_W > 1) begin : g_wide
      assign serial_word = {{(DATA_W-1){1'b0}}, cfg_data_i[0]};
    end else begin : g_bit
      assign serial_word = cfg_data_i;
    end
  endgenerate

  assign word_d = mode_q[1] ? cfg_data_i : serial_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= capture;
      if (capture) word_q <= word_d;
    end
  end

  assign status_drive_low_o = (state == ST_OFF) || (state == ST_POR) || (state == ST_RESET);
  assign done_drive_low_o   = status_drive_low_o || (state == ST_CONFIG);
  assign io_tristate_o      = (state != ST_USER);
  assign user_mode_o        = (state == ST_USER);
  assign cfg_word_o         = word_q;
  assign cfg_word_vld_o     = vld_q;

  // R1
  power_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (status_drive_low_o && done_drive_low_o && io_tristate_o && !user_mode_o));

  // R9
  req_low_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && !cfg_req_ni) |=> (status_drive_low_o && done_drive_low_o && io_tristate_o && !cfg_word_vld_o));

  // R4
  capture_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_word_vld_o |-> ($past(status_line_i) && $past(!status_drive_low_o) && $past(cfg_clk_en_i)));

  // R8
  user_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o |-> (!io_tristate_o && !done_drive_low_o && !status_drive_low_o));
endmodule

// File: tb/cfg_sequencer_bench.sv
module cfg_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int LEN_W      = 16;
  localparam int P_FAST     = 16;
  localparam int P_SLOW     = 64;
  localparam int P_INIT     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic cfg_req_n = 1'b1;
  logic clk_en = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic [LEN_W-1:0] total = 16'd3;
  logic ext_status_low = 1'b0;
  logic ext_done_low = 1'b0;
  logic status_line, done_line;
  logic status_dl, done_dl, io_tri, user_mode, word_vld;
  logic [DATA_W-1:0] word;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain wires with pull-ups
  assign status_line = !status_dl && !ext_status_low;
  assign done_line   = !done_dl && !ext_done_low;

  cfg_sequencer #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .POR_FAST(P_FAST),
    .POR_SLOW(P_SLOW), .INIT_CYCLES(P_INIT)
  ) u_cfg_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .mode_sel_i(mode_sel),
    .cfg_req_ni(cfg_req_n), .cfg_clk_en_i(clk_en), .cfg_data_i(data),
    .total_words_i(total), .status_line_i(status_line), .done_line_i(done_line),
    .status_drive_low_o(status_dl), .done_drive_low_o(done_dl),
    .io_tristate_o(io_tri), .user_mode_o(user_mode),
    .cfg_word_o(word), .cfg_word_vld_o(word_vld)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_off(input string req);
    chk(req, "status_low", status_dl, 1);
    chk(req, "done_low", done_dl, 1);
    chk(req, "io_tri", io_tri, 1);
    chk(req, "user", user_mode, 0);
  endtask

  // ends on the negedge where the status line is released
  task automatic power_up(input logic [1:0] m, input string req);
    int dly;
    dly = m[0] ? P_SLOW : P_FAST;
    @(negedge clk);
    pwr_good = 1'b1;
    mode_sel = m;
    @(negedge clk);
    mode_sel = ~m;  // must be ignored
    repeat (dly) @(negedge clk);
    chk(req, "status still low at delay end", status_dl, 1);
    @(negedge clk);
    chk(req, "status released after delay", status_dl, 0);
  endtask

  task automatic send(input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] exp, input string req);
    clk_en = 1'b1;
    data = d;
    @(negedge clk);
    clk_en = 1'b0;
    chk(req, "word valid", word_vld, 1);
    chk(req, "word value", word, exp);
  endtask

  task automatic expect_user_after(input string req);
    repeat (P_INIT) @(negedge clk);
    chk(req, "not yet user", user_mode, 0);
    chk(req, "io still tri", io_tri, 1);
    @(negedge clk);
    chk(req, "user mode", user_mode, 1);
    chk(req, "io driven", io_tri, 0);
    chk(req, "status released", status_dl, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_off("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_off("R1");
  endtask

  task automatic t_serial();
    total = 16'd3;
    power_up(2'b00, "R2");
    // status pulled low externally: no capture
    ext_status_low = 1'b1;
    clk_en = 1'b1;
    data = 8'hFF;
    @(negedge clk);
    clk_en = 1'b0;
    ext_status_low = 1'b0;
    chk("R4", "no capture with status low", word_vld, 0);
    @(negedge clk);
    chk("R4", "no capture without clock", word_vld, 0);
    send(8'hA5, 8'h01, "R5");
    send(8'h5A, 8'h00, "R5");
    chk("R6", "done held before last", done_dl, 1);
    send(8'h03, 8'h01, "R5");
    chk("R6", "done released", done_dl, 0);
    expect_user_after("R8");
  endtask

  task automatic t_parallel_hold();
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk_off("R1");
    total = 16'd2;
    power_up(2'b11, "R2");
    send(8'h3C, 8'h3C, "R5");
    ext_done_low = 1'b1;
    send(8'hC3, 8'hC3, "R5");
    chk("R6", "done released", done_dl, 0);
    repeat (5) @(negedge clk);
    chk("R7", "io tri while done held", io_tri, 1);
    chk("R7", "no user while done held", user_mode, 0);
    ext_done_low = 1'b0;
    expect_user_after("R7");
  endtask

  task automatic t_req_reset();
    total = 16'd4;
    cfg_req_n = 1'b0;
    @(negedge clk);
    chk("R9", "status low", status_dl, 1);
    chk("R9", "done low", done_dl, 1);
    chk("R9", "io tri", io_tri, 1);
    chk("R9", "user off", user_mode, 0);
    repeat (4) @(negedge clk);
    chk("R3", "held in reset", status_dl, 1);
    cfg_req_n = 1'b1;
    @(negedge clk);
    chk("R3", "status released", status_dl, 0);
    send(8'h11, 8'h11, "R9");
    send(8'h22, 8'h22, "R9");
    cfg_req_n = 1'b0;
    @(negedge clk);
    cfg_req_n = 1'b1;
    @(negedge clk);
    send(8'h33, 8'h33, "R9");
    send(8'h44, 8'h44, "R9");
    send(8'h55, 8'h55, "R9");
    chk("R9", "count cleared, done held", done_dl, 1);
    send(8'h66, 8'h66, "R9");
    chk("R9", "done after fresh count", done_dl, 0);
    expect_user_after("R8");
  endtask

  task automatic t_collide();
    total = 16'd2;
    cfg_req_n = 1'b0;
    @(negedge clk);
    cfg_req_n = 1'b1;
    @(negedge clk);
    send(8'h77, 8'h77, "R4");
    clk_en = 1'b1;
    data = 8'h88;
    cfg_req_n = 1'b0;
    @(negedge clk);
    clk_en = 1'b0;
    chk("R9", "capture suppressed", word_vld, 0);
    chk("R9", "done still low", done_dl, 1);
    chk("R9", "status low", status_dl, 1);
    cfg_req_n = 1'b1;
    @(negedge clk);
    send(8'h99, 8'h99, "R9");
    chk("R9", "one word not enough", done_dl, 1);
    send(8'hAA, 8'hAA, "R9");
    chk("R6", "done after two", done_dl, 0);
    expect_user_after("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_serial();
    t_parallel_hold();
    t_req_reset();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule